// File: doc/BRIEF.md
# Multi-Word Per-Bit Trigger Matcher

This block watches a word of monitored signals and decides, on every sample the upstream logic marks valid, whether that sample satisfies each of several programmable trigger words. Every bit of a trigger word carries its own condition code. A code can ask for a static level or for don't care. It can ask for an edge against the previous valid sample. It can also ask for a two-sample history condition: high twice, low twice, or unchanged.

The block keeps the last valid sample and, for each trigger word, a flag saying whether that history may be trusted. A trigger word matches when all of its bits are satisfied. Each word drives its own registered match pulse. Conditions are loaded one bit at a time through a small write port that names the word, the bit and the code.

Top module: `trig_matcher`

## Requirements
- R1: While rst_n is low, and in the cycle after it is sampled low, match_o is all zero. Reset sets every condition code to 0 (don't care) and marks every word's history as invalid.
- R2: Level codes act on the current sample bit: code 0 always passes, code 1 passes when the bit is 0, and code 2 passes when the bit is 1.
- R3: Edge codes compare against the previous valid sample: code 3 passes on 0 then 1, code 4 passes on 1 then 0, and code 5 passes on any change.
- R4: History codes compare against the previous valid sample: code 6 passes on 1 then 1, code 7 passes on 0 then 0, and code 8 passes on two equal values.
- R5: Codes 9 to 15 never pass, so a word holding one of them never matches.
- R6: Codes 3 to 8 fail on a sample unless an earlier valid sample was taken after the last reset and after the last write to that word.
- R7: match_o[k] is registered. It is high for exactly the one cycle after a sample_valid_i strobe whose sample satisfies every bit of word k, and it is low after any cycle without the strobe.
- R8: A word whose codes are all 0 matches on every valid sample.
- R9: The words are independent. A write to one word changes neither the codes nor the history validity of any other word.
- R10: When cfg_we_i is high, cfg_code_i is stored as the code for bit cfg_bit_i (0 to 31) of word cfg_word_i (0 to 3). The new code governs samples strobed from the next cycle on, and bit 31 is as programmable as bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_i | input | 32 | Monitored signal word |
| sample_valid_i | input | 1 | Marks sample_i as a sample to evaluate |
| cfg_we_i | input | 1 | Condition write strobe |
| cfg_word_i | input | 2 | Trigger word selected for the write |
| cfg_bit_i | input | 5 | Bit position selected for the write |
| cfg_code_i | input | 4 | Condition code to store |
| match_o | output | 4 | Registered match pulse, one bit per trigger word |

## Verification
The bench uses the default build of 32 bits and four trigger words. This puts the top bit position and the last word within reach, and lets all four words run at the same time under different condition mixes. Level, edge and history codes are exercised in separate words on one shared sample stream, so a fault in one class of code shows up against an unaffected neighbour. The history clearing is probed by rewriting a word between two samples that would otherwise match it, while another word keeps its history across the same write.

// File: rtl/trig_pkg.sv
`timescale 1ns/1ps
// Package: shared code width, condition code values and the per-bit
// evaluation function used by every trigger word.
package trig_pkg;

    localparam int CODE_W = 4;

    localparam logic [CODE_W-1:0] CODE_ANY  = 4'd0;
    localparam logic [CODE_W-1:0] CODE_LOW  = 4'd1;
    localparam logic [CODE_W-1:0] CODE_HIGH = 4'd2;
    localparam logic [CODE_W-1:0] CODE_RISE = 4'd3;
    localparam logic [CODE_W-1:0] CODE_FALL = 4'd4;
    localparam logic [CODE_W-1:0] CODE_EDGE = 4'd5;
    localparam logic [CODE_W-1:0] CODE_HH   = 4'd6;
    localparam logic [CODE_W-1:0] CODE_LL   = 4'd7;
    localparam logic [CODE_W-1:0] CODE_SAME = 4'd8;
    localparam logic [CODE_W-1:0] CODE_LAST = CODE_SAME;

    // Decide one bit: cur is the present sample bit, prv the previous valid
    // sample bit, hist says whether prv may be used. Unlisted codes fail.
    function automatic logic bit_ok(input logic [CODE_W-1:0] code,
                                    input logic cur,
                                    input logic prv,
                                    input logic hist);
        logic r;
        case (code)
            CODE_ANY:  r = 1'b1;
            CODE_LOW:  r = !cur;
            CODE_HIGH: r = cur;
            CODE_RISE: r = hist && !prv && cur;
            CODE_FALL: r = hist && prv && !cur;
            CODE_EDGE: r = hist && (prv != cur);
            CODE_HH:   r = hist && prv && cur;
            CODE_LL:   r = hist && !prv && !cur;
            CODE_SAME: r = hist && (prv == cur);
            default:   r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/trig_cond_bank.sv
`timescale 1ns/1ps
// Condition storage: one code register per bit per trigger word, written one
// cell at a time. Also reports which word a write touched so its history can
// be invalidated. Assumes wr_word and wr_bit stay in range.
module trig_cond_bank
    import trig_pkg::*;
#(
    parameter  int WIDTH     = 32,
    parameter  int NUM_WORDS = 4,
    localparam int WSEL_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
    localparam int BSEL_W    = (WIDTH > 1) ? $clog2(WIDTH) : 1,
    localparam int FLAT_W    = NUM_WORDS * WIDTH * CODE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [WSEL_W-1:0]    wr_word,
    input  logic [BSEL_W-1:0]    wr_bit,
    input  logic [CODE_W-1:0]    wr_code,
    output logic [FLAT_W-1:0]    cond_flat,
    output logic [NUM_WORDS-1:0] wr_hit
);

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        // Flag a write aimed at this word.
        assign wr_hit[w] = wr_en && (wr_word == WSEL_W'(w));

        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            logic [CODE_W-1:0] cell_q;

            // Hold the code of one bit; reset to don't care.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cell_q <= CODE_ANY;
                else if (wr_hit[w] && (wr_bit == BSEL_W'(b)))
                    cell_q <= wr_code;
            end

            assign cond_flat[(w*WIDTH + b)*CODE_W +: CODE_W] = cell_q;
        end
    end

endmodule

// File: rtl/trig_sample_hist.sv
`timescale 1ns/1ps
// Sample history: keeps the last valid sample and, per trigger word, whether
// a valid sample has been taken since reset and since that word's last write.
// Assumes clr pulses for one cycle per write.
module trig_sample_hist #(
    parameter int WIDTH     = 32,
    parameter int NUM_WORDS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 valid,
    input  logic [WIDTH-1:0]     sample,
    input  logic [NUM_WORDS-1:0] clr,
    output logic [WIDTH-1:0]     prev,
    output logic [NUM_WORDS-1:0] hist_ok
);

    logic [WIDTH-1:0] prev_q;

    // Capture every valid sample as the reference for the next one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_q <= '0;
        else if (valid)
            prev_q <= sample;
    end

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_flag
        logic ok_q;

        // A write invalidates history; a later valid sample restores it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ok_q <= 1'b0;
            else if (clr[w])
                ok_q <= 1'b0;
            else if (valid)
                ok_q <= 1'b1;
        end

        assign hist_ok[w] = ok_q;
    end

    assign prev = prev_q;

endmodule

// File: rtl/trig_word_match.sv
`timescale 1ns/1ps
// One trigger word: evaluates every bit against its code and registers the
// AND of all bit results as a one-cycle pulse per valid sample.
module trig_word_match
    import trig_pkg::*;
#(
    parameter  int WIDTH  = 32,
    localparam int COND_W = WIDTH * CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic [WIDTH-1:0]  cur,
    input  logic [WIDTH-1:0]  prv,
    input  logic              hist,
    input  logic [COND_W-1:0] cond,
    output logic              match
);

    logic [WIDTH-1:0] pass;
    logic             match_q;

    for (genvar b = 0; b < WIDTH; b++) begin : g_eval
        assign pass[b] = bit_ok(cond[b*CODE_W +: CODE_W], cur[b], prv[b], hist);
    end

    // Register the word decision for the strobed sample only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            match_q <= 1'b0;
        else
            match_q <= valid && (&pass);
    end

    assign match = match_q;

endmodule

// File: rtl/trig_matcher.sv
`timescale 1ns/1ps
// Top: several trigger words evaluated in parallel against a shared sample
// stream and a shared history, each with its own registered match output.
// Assumes the write port and sample stream are synchronous to clk.
module trig_matcher
    import trig_pkg::*;
#(
    parameter  int WIDTH     = 32,
    parameter  int NUM_WORDS = 4,
    localparam int WSEL_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
    localparam int BSEL_W    = (WIDTH > 1) ? $clog2(WIDTH) : 1,
    localparam int COND_W    = WIDTH * CODE_W,
    localparam int FLAT_W    = NUM_WORDS * COND_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [WIDTH-1:0]     sample_i,
    input  logic                 sample_valid_i,
    input  logic                 cfg_we_i,
    input  logic [WSEL_W-1:0]    cfg_word_i,
    input  logic [BSEL_W-1:0]    cfg_bit_i,
    input  logic [CODE_W-1:0]    cfg_code_i,
    output logic [NUM_WORDS-1:0] match_o
);

    logic [FLAT_W-1:0]    cfg_flat;
    logic [NUM_WORDS-1:0] wr_hit;
    logic [WIDTH-1:0]     prev_sample;
    logic [NUM_WORDS-1:0] hist_ok;

    trig_cond_bank #(
        .WIDTH     (WIDTH),
        .NUM_WORDS (NUM_WORDS)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we_i),
        .wr_word   (cfg_word_i),
        .wr_bit    (cfg_bit_i),
        .wr_code   (cfg_code_i),
        .cond_flat (cfg_flat),
        .wr_hit    (wr_hit)
    );

    trig_sample_hist #(
        .WIDTH     (WIDTH),
        .NUM_WORDS (NUM_WORDS)
    ) u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (sample_valid_i),
        .sample  (sample_i),
        .clr     (wr_hit),
        .prev    (prev_sample),
        .hist_ok (hist_ok)
    );

    for (genvar k = 0; k < NUM_WORDS; k++) begin : g_match
        trig_word_match #(
            .WIDTH (WIDTH)
        ) u_word (
            .clk   (clk),
            .rst_n (rst_n),
            .valid (sample_valid_i),
            .cur   (sample_i),
            .prv   (prev_sample),
            .hist  (hist_ok[k]),
            .cond  (cfg_flat[k*COND_W +: COND_W]),
            .match (match_o[k])
        );
    end

endmodule

// File: rtl/trig_matcher_chk.sv
`timescale 1ns/1ps
// Checker: temporal properties of the trigger matcher, attached by bind.
// Assumes it sees the top's condition store and history flags.
module trig_matcher_chk
    import trig_pkg::*;
#(
    parameter  int WIDTH     = 32,
    parameter  int NUM_WORDS = 4,
    localparam int WSEL_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
    localparam int COND_W    = WIDTH * CODE_W,
    localparam int FLAT_W    = NUM_WORDS * COND_W
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sample_valid_i,
    input logic                 cfg_we_i,
    input logic [WSEL_W-1:0]    cfg_word_i,
    input logic [FLAT_W-1:0]    cfg_flat,
    input logic [NUM_WORDS-1:0] hist_ok,
    input logic [NUM_WORDS-1:0] match_o
);

    // R1: a reset cycle leaves every match output low next cycle.
    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (match_o == '0));

    for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
        logic [WIDTH-1:0] bad;
        logic             all_dc;

        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            assign bad[b] = cfg_flat[k*COND_W + b*CODE_W +: CODE_W] > CODE_LAST;
        end
        assign all_dc = (cfg_flat[k*COND_W +: COND_W] == '0);

        // R7: a match pulse only follows a strobed sample.
        p_pulse_needs_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
            match_o[k] |-> $past(sample_valid_i));

        // R8: an all-don't-care word matches every strobed sample.
        p_all_dont_care_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (sample_valid_i && all_dc) |=> match_o[k]);

        // R5: an unused code anywhere in the word blocks the match.
        p_unused_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (|bad) |=> !match_o[k]);

        // R6: a write to the word drops its history validity.
        p_write_clears_history_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we_i && (cfg_word_i == WSEL_W'(k))) |=> !hist_ok[k]);
    end

endmodule

bind trig_matcher trig_matcher_chk #(
    .WIDTH     (WIDTH),
    .NUM_WORDS (NUM_WORDS)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .sample_valid_i (sample_valid_i),
    .cfg_we_i       (cfg_we_i),
    .cfg_word_i     (cfg_word_i),
    .cfg_flat       (cfg_flat),
    .hist_ok        (hist_ok),
    .match_o        (match_o)
);

// File: tb/trig_matcher_test.sv
`timescale 1ns/1ps
// Bench: configures four trigger words, walks a vector table, then runs
// directed tests for unused codes, history clearing, independence, bit 31
// and reset.
module trig_matcher_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] sample_i = '0;
    logic        sample_valid_i = 1'b0;
    logic        cfg_we_i = 1'b0;
    logic [1:0]  cfg_word_i = '0;
    logic [4:0]  cfg_bit_i = '0;
    logic [3:0]  cfg_code_i = '0;
    logic [3:0]  match_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    trig_matcher uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .sample_i       (sample_i),
        .sample_valid_i (sample_valid_i),
        .cfg_we_i       (cfg_we_i),
        .cfg_word_i     (cfg_word_i),
        .cfg_bit_i      (cfg_bit_i),
        .cfg_code_i     (cfg_code_i),
        .match_o        (match_o)
    );

    // Entry: {sample, strobe, expected match for words 3..0}.
    // Word 0: b0 high, b1 low, b2 rising, b3 falling.
    // Word 1: b0 either edge, b1 double high, b2 double low, b3 no-change.
    // Word 2: all don't care. Word 3: b31 high, b0 no-change.
    localparam logic [36:0] VEC [9] = '{
        {32'h0000_0009, 1'b1, 4'b0100},
        {32'h0000_0005, 1'b1, 4'b0101},
        {32'h0000_0005, 1'b0, 4'b0000},
        {32'h8000_0004, 1'b1, 4'b0100},
        {32'h8000_0002, 1'b1, 4'b1100},
        {32'h8000_0003, 1'b1, 4'b0110},
        {32'h0000_0008, 1'b1, 4'b0100},
        {32'h0000_000D, 1'b1, 4'b0100},
        {32'h0000_0005, 1'b1, 4'b0100}
    };

    task automatic check(input logic [3:0] exp, input string tag);
        checks++;
        if (match_o !== exp) begin
            fails++;
            $display("FAIL %s: match_o=%b expected %b", tag, match_o, exp);
        end
    endtask

    // Present one sample at a falling edge, check the pulse one clock later.
    task automatic step(input logic [31:0] s, input logic v,
                        input logic [3:0] exp, input string tag);
        sample_i       = s;
        sample_valid_i = v;
        @(negedge clk);
        check(exp, tag);
        sample_valid_i = 1'b0;
    endtask

    task automatic cfg_write(input logic [1:0] w, input logic [4:0] b,
                             input logic [3:0] code);
        cfg_word_i = w;
        cfg_bit_i  = b;
        cfg_code_i = code;
        cfg_we_i   = 1'b1;
        @(negedge clk);
        cfg_we_i   = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(4'b0000, "R1 match low in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(4'b0000, "R1 match low after reset");
        step(32'h0, 1'b1, 4'b1111, "R1/R8 reset codes are don't care");

        cfg_write(2'd0, 5'd0, 4'd2);
        cfg_write(2'd0, 5'd1, 4'd1);
        cfg_write(2'd0, 5'd2, 4'd3);
        cfg_write(2'd0, 5'd3, 4'd4);
        cfg_write(2'd1, 5'd0, 4'd5);
        cfg_write(2'd1, 5'd1, 4'd6);
        cfg_write(2'd1, 5'd2, 4'd7);
        cfg_write(2'd1, 5'd3, 4'd8);
        cfg_write(2'd3, 5'd31, 4'd2);
        cfg_write(2'd3, 5'd0, 4'd8);

        for (int i = 0; i < 9; i++)
            step(VEC[i][36:5], VEC[i][4], VEC[i][3:0], "R2 R3 R4 R8 table");

        // R7: one pulse, then nothing without a strobe.
        step(32'h5, 1'b1, 4'b0100, "R7 strobed");
        step(32'h5, 1'b0, 4'b0000, "R7 no strobe");

        // R5: an unused code in word 2 blocks it; restoring brings it back.
        cfg_write(2'd2, 5'd5, 4'd9);
        step(32'h0, 1'b1, 4'b0000, "R5 unused code");
        cfg_write(2'd2, 5'd5, 4'd0);
        step(32'h0, 1'b1, 4'b0100, "R5 restored");

        // R6: a rewrite of word 1 suppresses history for one sample.
        step(32'h2, 1'b1, 4'b0100, "R6 setup");
        cfg_write(2'd1, 5'd3, 4'd8);
        step(32'h3, 1'b1, 4'b0100, "R6 suppressed after write");
        step(32'h2, 1'b1, 4'b0110, "R6 second sample matches");

        // R9: a write to word 1 leaves word 3 history intact.
        step(32'h8000_0001, 1'b1, 4'b0100, "R9 setup");
        cfg_write(2'd1, 5'd3, 4'd8);
        step(32'h8000_0001, 1'b1, 4'b1100, "R9 other word keeps history");

        // R10: bit 31 of word 3 reprogrammed to low.
        cfg_write(2'd3, 5'd31, 4'd1);
        step(32'h8000_0001, 1'b1, 4'b0100, "R10 bit 31 now low");
        step(32'h0000_0001, 1'b1, 4'b1100, "R10 bit 31 low passes");

        // R1: reset mid-run clears pulses, codes and history.
        rst_n          = 1'b0;
        sample_i       = 32'h0;
        sample_valid_i = 1'b1;
        @(negedge clk);
        check(4'b0000, "R1 reset mid-run");
        @(negedge clk);
        check(4'b0000, "R1 reset held");
        sample_valid_i = 1'b0;
        rst_n          = 1'b1;
        step(32'h0, 1'b1, 4'b1111, "R1 codes cleared by reset");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule